// File: doc/BRIEF.md
# Command Response Capture FIFO

This block sits behind the command sender of a memory-card host. Once a command has gone out, the sender pulses `start_i` with a three-bit code that says which kind of reply to expect. The block then watches the command line. It takes one sample for every card-clock strobe, finds the start bit of the reply and shifts in the whole frame. For short replies it checks the frame's CRC7. It reports completion, a CRC mismatch or a missing reply.

The captured frame is read out through a single 16-bit port, one halfword per read strobe. A short reply gives three halfwords and a long reply gives nine. The halfwords straddle byte boundaries: software builds each 32-bit word from the low byte of one halfword, the whole of the next halfword and one byte of the third. The flags stay set until the next `start_i`.

Top module: `rsp_capture`

## Requirements
- R1: Format code 1 expects a 48-bit reply that is CRC-checked. Code 3 expects a 48-bit reply that is not checked. Code 2 expects a 136-bit reply that is not checked. Codes 0 and 4 to 7 expect no reply: `rsp_done_o` pulses in the cycle after `start_i`, no flag is set, and the FIFO stays empty.
- R2: The first strobe after `start_i` that samples 0 is taken as the start bit (frame bit 0). Strobes that sample 1 before it are not captured.
- R3: A reply may start on any of the first 64 strobes after `start_i`. If all 64 of those strobes sample 1, `rsp_timeout_o` is set and `rsp_done_o` pulses in the cycle after the 64th strobe. The FIFO stays empty.
- R4: A 48-bit frame f[47:0] (f[47] is the start bit) is read as three halfwords in this order: f[47:32], f[31:16], {f[7:0], f[15:8]}. The 32-bit argument f[39:8] is therefore {hw0[7:0], hw1, hw2[7:0]}.
- R5: A 136-bit frame is extended by a zero byte to 144 bits. It is read as nine halfwords, most significant first. Word i of the 128-bit payload f[127:0] is {hw(2i)[7:0], hw(2i+1), hw(2i+2)[15:8]}.
- R6: The CRC7 uses the polynomial x^7+x^3+1 and starts from zero. It covers frame bits 47 down to 8 and is compared with bits 7:1. With code 1, a mismatch sets `crc_err_o`. With codes 2 and 3 the flag is never set. `crc_err_o` and `rsp_timeout_o` are never set together.
- R7: `rsp_done_o` is a one-cycle pulse. It comes in the cycle after the strobe that carried the last frame bit, and once per reply.
- R8: A read strobe on an empty FIFO, or one after all halfwords have been read, returns 0 and does not move the read position.
- R9: `crc_err_o` and `rsp_timeout_o` stay set until the next `start_i`. `start_i` clears them in the following cycle and empties the FIFO.
- R10: `rd_data_o` is registered. A read strobe in cycle n gives its halfword in cycle n+1, and that value is held until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command sent; arms capture and clears flags and FIFO |
| rsp_fmt_i | input | 3 | Expected reply code, sampled with `start_i` |
| cmd_line_i | input | 1 | Command line level, valid with `cmd_stb_i` |
| cmd_stb_i | input | 1 | One pulse per card-clock sample edge |
| rd_i | input | 1 | Halfword read strobe |
| rd_data_o | output | 16 | Last halfword read |
| rsp_done_o | output | 1 | End-of-response event pulse |
| crc_err_o | output | 1 | Reply CRC mismatch, sticky |
| rsp_timeout_o | output | 1 | No start bit within the window, sticky |

## Verification
The bench targets the edges of the timeout window. A reply that starts on the 64th strobe must be accepted, and a 64th idle strobe must time out. A counter that is off by one either loses a valid reply or hangs one strobe too long. The short frame's last halfword, which swaps its bytes, and the nine-halfword long stream are both rebuilt into 32-bit words and compared with the sent payload. A byte mapping that is wrong or shifted then shows up as a wrong argument. Other checks confirm that a corrupted CRC is flagged only for code 1, that reads past the end return 0 and hold their position, and that the done pulse is one cycle wide. A pulse that is too wide, or missing for a reply with no response, would change the count of done events.

// File: rtl/rsp_cap_pkg.sv
package rsp_cap_pkg;
  localparam logic [2:0] FMT_NONE = 3'd0;
  localparam logic [2:0] FMT_R1   = 3'd1;
  localparam logic [2:0] FMT_R2   = 3'd2;
  localparam logic [2:0] FMT_R3   = 3'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_RECV} rx_state_e;
endpackage

// File: rtl/rsp_crc7.sv
module rsp_crc7 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic fb;
  assign fb = bit_i ^ crc_o[6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= {crc_o[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  end
endmodule

// File: rtl/rsp_cap_rx.sv
module rsp_cap_rx
  import rsp_cap_pkg::*;
#(
  parameter int unsigned SHORT_BITS   = 48,
  parameter int unsigned LONG_BITS    = 136,
  parameter int unsigned TIMEOUT_CLKS = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [2:0]           fmt_i,
  input  logic                 line_i,
  input  logic                 stb_i,
  output logic [LONG_BITS-1:0] frame_o,
  output logic                 long_o,
  output logic                 fill_o,
  output logic                 done_o,
  output logic                 crc_err_o,
  output logic                 timeout_o
);
  localparam int unsigned CNT_W    = $clog2(LONG_BITS + 1);
  localparam int unsigned TO_W     = $clog2(TIMEOUT_CLKS);
  localparam int unsigned CRC_SPAN = SHORT_BITS - 8;

  rx_state_e           state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [TO_W-1:0]     wait_cnt;
  logic                chk_q;
  logic                last_bit;
  logic                crc_en;
  logic [6:0]          crc_val;

  assign last_bit = bit_cnt == (long_o ? CNT_W'(LONG_BITS - 1) : CNT_W'(SHORT_BITS - 1));
  assign crc_en   = !start_i && stb_i && (state == ST_RECV) && (bit_cnt < CNT_W'(CRC_SPAN));

  rsp_crc7 u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_i),
    .en_i  (crc_en),
    .bit_i (line_i),
    .crc_o (crc_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      wait_cnt  <= '0;
      chk_q     <= 1'b0;
      long_o    <= 1'b0;
      frame_o   <= '0;
      fill_o    <= 1'b0;
      done_o    <= 1'b0;
      crc_err_o <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      fill_o <= 1'b0;
      done_o <= 1'b0;
      if (start_i) begin
        crc_err_o <= 1'b0;
        timeout_o <= 1'b0;
        frame_o   <= '0;
        bit_cnt   <= '0;
        wait_cnt  <= '0;
        unique case (fmt_i)
          FMT_R1: begin state <= ST_HUNT; long_o <= 1'b0; chk_q <= 1'b1; end
          FMT_R2: begin state <= ST_HUNT; long_o <= 1'b1; chk_q <= 1'b0; end
          FMT_R3: begin state <= ST_HUNT; long_o <= 1'b0; chk_q <= 1'b0; end
          default: begin state <= ST_IDLE; done_o <= 1'b1; end
        endcase
      end else if (stb_i) begin
        unique case (state)
          ST_HUNT: begin
            if (!line_i) begin
              state   <= ST_RECV;
              bit_cnt <= CNT_W'(1);
            end else if (wait_cnt == TO_W'(TIMEOUT_CLKS - 1)) begin
              state     <= ST_IDLE;
              timeout_o <= 1'b1;
              done_o    <= 1'b1;
            end else begin
              wait_cnt <= wait_cnt + 1'b1;
            end
          end
          ST_RECV: begin
            frame_o <= {frame_o[LONG_BITS-2:0], line_i};
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              state     <= ST_IDLE;
              done_o    <= 1'b1;
              fill_o    <= 1'b1;
              crc_err_o <= chk_q && (crc_val != frame_o[6:0]);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
  // R3
  timeout_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);
  // R6
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(crc_err_o && timeout_o));
  // R9
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!crc_err_o && !timeout_o));
endmodule

// File: rtl/rsp_cap_rd.sv
module rsp_cap_rd #(
  parameter int unsigned SHORT_BITS = 48,
  parameter int unsigned LONG_BITS  = 136
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 load_i,
  input  logic                 long_i,
  input  logic [LONG_BITS-1:0] frame_i,
  input  logic                 rd_i,
  output logic [15:0]          data_o
);
  localparam int unsigned SHORT_HW = SHORT_BITS / 16;
  localparam int unsigned LONG_HW  = (LONG_BITS + 15) / 16;
  localparam int unsigned PAD_W    = LONG_HW * 16 - LONG_BITS;
  localparam int unsigned PTR_W    = $clog2(LONG_HW + 1);

  logic [PTR_W-1:0]     ptr, cnt;
  logic [LONG_HW*16-1:0] padded, shifted;
  logic [15:0]           hw_long, hw_short, hw_sel;
  logic                  empty;

  assign empty   = ptr == cnt;
  assign padded  = {frame_i, {PAD_W{1'b0}}};
  assign shifted = padded >> (16 * (LONG_HW - 1 - int'(ptr)));
  assign hw_long = (int'(ptr) < LONG_HW) ? shifted[15:0] : 16'h0;

  always_comb begin
    unique case (int'(ptr))
      0:       hw_short = frame_i[47:32];
      1:       hw_short = frame_i[31:16];
      2:       hw_short = {frame_i[7:0], frame_i[15:8]}; // argument low byte on the low lane
      default: hw_short = 16'h0;
    endcase
  end

  assign hw_sel = long_i ? hw_long : hw_short;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr    <= '0;
      cnt    <= '0;
      data_o <= '0;
    end else if (clr_i) begin
      ptr <= '0;
      cnt <= '0;
    end else if (load_i) begin
      ptr <= '0;
      cnt <= long_i ? PTR_W'(LONG_HW) : PTR_W'(SHORT_HW);
    end else if (rd_i) begin
      if (empty) data_o <= '0;
      else begin
        data_o <= hw_sel;
        ptr    <= ptr + 1'b1;
      end
    end
  end

  // R8
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty && !clr_i && !load_i) |=> (data_o == 16'h0 && $stable(ptr)));
  // R1
  ptr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr <= cnt);
  // R10
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(data_o));
endmodule

// File: rtl/rsp_capture.sv
module rsp_capture #(
  parameter int unsigned SHORT_BITS   = 48,
  parameter int unsigned LONG_BITS    = 136,
  parameter int unsigned TIMEOUT_CLKS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [2:0]  rsp_fmt_i,
  input  logic        cmd_line_i,
  input  logic        cmd_stb_i,
  input  logic        rd_i,
  output logic [15:0] rd_data_o,
  output logic        rsp_done_o,
  output logic        crc_err_o,
  output logic        rsp_timeout_o
);
  logic [LONG_BITS-1:0] frame;
  logic                 is_long, fill;

  rsp_cap_rx #(
    .SHORT_BITS  (SHORT_BITS),
    .LONG_BITS   (LONG_BITS),
    .TIMEOUT_CLKS(TIMEOUT_CLKS)
  ) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .fmt_i    (rsp_fmt_i),
    .line_i   (cmd_line_i),
    .stb_i    (cmd_stb_i),
    .frame_o  (frame),
    .long_o   (is_long),
    .fill_o   (fill),
    .done_o   (rsp_done_o),
    .crc_err_o(crc_err_o),
    .timeout_o(rsp_timeout_o)
  );

  rsp_cap_rd #(
    .SHORT_BITS(SHORT_BITS),
    .LONG_BITS (LONG_BITS)
  ) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .load_i (fill),
    .long_i (is_long),
    .frame_i(frame),
    .rd_i   (rd_i),
    .data_o (rd_data_o)
  );
endmodule

// File: tb/rsp_capture_tb.sv
`timescale 1ns/1ps
module rsp_capture_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  rsp_fmt_i = 3'd0;
  logic        cmd_line_i = 1'b1;
  logic        cmd_stb_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        rsp_done_o, crc_err_o, rsp_timeout_o;

  int n_chk = 0, n_bad = 0, done_seen = 0;

  always #2 clk_i = ~clk_i;

  rsp_capture u_dut (.*);

  always @(negedge clk_i) if (rsp_done_o) done_seen++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  task automatic start_rsp(logic [2:0] fmt);
    @(negedge clk_i); start_i = 1'b1; rsp_fmt_i = fmt;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic send_bit(logic b);
    @(negedge clk_i); cmd_line_i = b; cmd_stb_i = 1'b1;
    @(negedge clk_i); cmd_stb_i = 1'b0; cmd_line_i = 1'b1;
  endtask

  task automatic rd_hw(output logic [15:0] v);
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; v = rd_data_o;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R9 reset crc_err", crc_err_o, 0);
    check("R9 reset timeout", rsp_timeout_o, 0);
    check("R7 reset done", rsp_done_o, 0);
    rd_hw(v);
    check("R8 read before any reply", v, 0);
  endtask

  task automatic t_short(logic [2:0] fmt, logic [5:0] idx, logic [31:0] arg, bit corrupt, int pre_ones);
    logic [47:0] f;
    logic [15:0] h0, h1, h2, h3;
    int d0;
    f = {2'b00, idx, arg, 8'h00};
    f[7:1] = crc7(f[47:8]);
    f[0] = 1'b1;
    if (corrupt) f[1] = ~f[1];
    start_rsp(fmt);
    d0 = done_seen;
    for (int i = 0; i < pre_ones; i++) send_bit(1'b1);   // R2 idle ones before start bit
    for (int i = 47; i >= 0; i--) begin
      send_bit(f[i]);
      if (i == 0) check("R7 done right after last bit", rsp_done_o, 1);
    end
    repeat (3) @(negedge clk_i);
    check("R7 single done pulse", done_seen - d0, 1);
    check("R6 crc flag", crc_err_o, (corrupt && fmt == 3'd1) ? 1 : 0);
    check("R3 no timeout on reply", rsp_timeout_o, 0);
    rd_hw(h0); rd_hw(h1);
    repeat (3) @(negedge clk_i);
    check("R10 data held after read", rd_data_o, h1);
    rd_hw(h2); rd_hw(h3);
    check("R4 hw0", h0, f[47:32]);
    check("R4 hw1", h1, f[31:16]);
    check("R4 hw2", h2, {f[7:0], f[15:8]});
    check("R4 argument rebuilt", {h0[7:0], h1, h2[7:0]}, arg);
    check("R8 read past end", h3, 0);
    rd_hw(h3);
    check("R8 second read past end", h3, 0);
  endtask

  task automatic t_long(logic [127:0] pl, bit corrupt);
    logic [135:0] f;
    logic [143:0] p;
    logic [15:0] h [9];
    logic [15:0] extra;
    f = {2'b00, 6'h3F, pl};
    if (corrupt) f[1] = ~f[1];
    p = {f, 8'h00};
    start_rsp(3'd2);
    for (int i = 135; i >= 0; i--) send_bit(f[i]);
    check("R7 done after long", rsp_done_o, 1);
    check("R6 no crc check on long", crc_err_o, 0);
    for (int k = 0; k < 9; k++) begin
      rd_hw(h[k]);
      check("R5 long hw", h[k], p[143-16*k -: 16]);
    end
    for (int w = 0; w < 4; w++)
      check("R5 long word rebuilt", {h[2*w][7:0], h[2*w+1], h[2*w+2][15:8]}, f[127-32*w -: 32]);
    rd_hw(extra);
    check("R8 long read past end", extra, 0);
  endtask

  task automatic t_none(logic [2:0] fmt);
    logic [15:0] v;
    int d0 = done_seen;
    @(negedge clk_i); start_i = 1'b1; rsp_fmt_i = fmt;
    @(negedge clk_i); start_i = 1'b0;
    check("R1 no-reply done next cycle", rsp_done_o, 1);
    repeat (3) @(negedge clk_i);
    check("R1 no-reply single done", done_seen - d0, 1);
    check("R1 no-reply no timeout", rsp_timeout_o, 0);
    rd_hw(v);
    check("R1 no-reply FIFO empty", v, 0);
  endtask

  task automatic t_timeout();
    logic [15:0] v;
    start_rsp(3'd1);
    for (int i = 0; i < 63; i++) send_bit(1'b1);
    check("R3 no timeout before 64th", rsp_timeout_o, 0);
    send_bit(1'b1);
    check("R3 timeout flag", rsp_timeout_o, 1);
    check("R3 done with timeout", rsp_done_o, 1);
    repeat (5) send_bit(1'b0);  // late line activity is not captured
    rd_hw(v);
    check("R3 FIFO empty after timeout", v, 0);
    check("R9 timeout sticky", rsp_timeout_o, 1);
    @(negedge clk_i); start_i = 1'b1; rsp_fmt_i = 3'd0;
    @(negedge clk_i); start_i = 1'b0;
    check("R9 start clears timeout", rsp_timeout_o, 0);
  endtask

  task automatic t_crc_sticky();
    t_short(3'd1, 6'd17, 32'hCAFE_0001, 1'b1, 0);
    repeat (10) @(negedge clk_i);
    check("R9 crc flag sticky", crc_err_o, 1);
    @(negedge clk_i); start_i = 1'b1; rsp_fmt_i = 3'd3;
    @(negedge clk_i); start_i = 1'b0;
    check("R9 start clears crc flag", crc_err_o, 0);
    repeat (2) send_bit(1'b1);
    start_rsp(3'd0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_short(3'd1, 6'd3, 32'h1234_5678, 1'b0, 0);   // R1 R4
    t_short(3'd1, 6'd7, 32'hA5A5_00FF, 1'b1, 5);   // R6 corrupted, R2 leading ones
    t_short(3'd3, 6'h3F, 32'h80FF_8000, 1'b1, 2);  // R6 unchecked format
    t_short(3'd1, 6'd13, 32'h0000_0001, 1'b0, 63); // R3 start bit on 64th strobe
    t_long(128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687, 1'b0);
    t_long(128'hFFFF_0000_AAAA_5555_1357_9BDF_2468_ACE1, 1'b1);
    t_none(3'd0);
    t_none(3'd6);
    t_timeout();
    t_crc_sticky();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule